// File: doc/BRIEF.md
# Receive Header Alignment Pad Inserter

This block sits after a 64-bit Ethernet receive path and turns its beat stream into a stream with valid/ready flow control. In front of each frame's destination address it puts six bytes. Once those six bytes are in place, any IP header that follows starts on a 64-bit word boundary. The first of the six bytes carries a fixed ingress-port label, and the other five are zero. Every input beat is therefore moved six byte lanes up. The two lowest bytes of each input word complete the current output word, and the six upper bytes are held over for the next one. When the last input word has more than two valid bytes, the frame ends with one extra output beat that holds those leftover bytes.

The receive side has no ready signal, so input beats enter a small skid FIFO first. If a beat arrives while that FIFO is full, the beat is dropped and a one-cycle drop pulse is raised. A beat that is not a start-of-frame, arriving while no frame is open, is discarded. A synchronous active-low reset, or the synchronous clear input, empties the FIFO and the output register and returns the aligner to idle.

Top module: `rxpad_top`

## Requirements
- R1: Byte lane k is bits [8k+7:8k], and lane 0 is the first byte on the wire. The first output beat of a frame has lane 0 equal to PORT_LABEL, lanes 1 to 5 equal to zero, and lanes 6 and 7 equal to input lanes 0 and 1 of the start-of-frame word.
- R2: Every later output beat has lanes 0 to 5 equal to lanes 2 to 7 of the previous input word of the frame, and lanes 6 and 7 equal to lanes 0 and 1 of the current input word.
- R3: The input occupancy on the end-of-frame word gives the count n of valid bytes from lane 0, with 0 meaning 8. If n is 2 or less, that word's output beat is the final one: it carries tlast, and tuser[2:0] is (n+6) mod 8, where 0 means a full word.
- R4: If n is 3 or more, one extra output beat follows. Its lanes 0 to 5 are lanes 2 to 7 of the last input word and its lanes 6 and 7 are zero. It carries tlast, and tuser[2:0] is n-2 (6 for a full word).
- R5: On the tlast beat, tuser[3] equals the error flag of the end-of-frame input word. On every beat without tlast, tuser is zero.
- R6: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata, m_tuser and m_tlast hold their values.
- R7: Input beats are buffered in a FIFO of FIFO_DEPTH entries. A valid beat arriving while the FIFO is full is dropped, and drop_pulse is high for the one cycle after that clock edge. With FIFO_DEPTH 4 and m_tready held low, five beats are kept (four in the FIFO and one in the output register) and the sixth is dropped.
- R8: An input beat without start-of-frame that arrives while no frame is open produces no output.
- R9: A cycle with clear high, or with rst_n low, empties the FIFO and the output register, discards any partial frame, and leaves m_tvalid low after that edge.
- R10: After reset, m_tvalid and drop_pulse are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the MAC data domain |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous flush back to idle |
| in_data | input | 64 | Receive word, lane 0 in bits [7:0] |
| in_occ | input | 3 | Valid-byte count of the end-of-frame word, 0 means 8 |
| in_sof | input | 1 | Word starts a frame |
| in_eof | input | 1 | Word ends a frame |
| in_err | input | 1 | Frame error, read on the end-of-frame word |
| in_valid | input | 1 | Word is present this cycle |
| m_tdata | output | 64 | Output stream data |
| m_tuser | output | 4 | [2:0] final-beat occupancy, [3] error, both on tlast only |
| m_tlast | output | 1 | Final beat of a frame |
| m_tvalid | output | 1 | Output beat is present |
| m_tready | input | 1 | Downstream accepts the beat |
| drop_pulse | output | 1 | An input beat was lost because the FIFO was full |

## Verification
If the six-byte carry register held the wrong value, lanes 0 to 5 of the very next output beat would be wrong. A stale carry from the previous frame would show up in the first beat after a second start-of-frame. If the frame-state register went wrong, the label pattern would appear in the middle of a frame, or tlast would be missing or arrive one beat early or late. That is visible on the same frame's final beat. A fault in the FIFO pointers would show within a few beats as a duplicated or skipped word, or as a drop pulse at an occupancy other than four.

// File: rtl/rxpad_pkg.sv
// Package: shared sizes, the buffered beat record and the aligner states
// for the receive pad inserter. It assumes a 64-bit word made of 8 lanes,
// with lane 0 in the low byte.
package rxpad_pkg;

    localparam int BEAT_BYTES = 8;
    localparam int PAD_BYTES  = 6;
    localparam int DATA_W     = BEAT_BYTES * 8;
    localparam int OCC_W      = $clog2(BEAT_BYTES);
    localparam int USER_W     = OCC_W + 1;
    localparam int KEEP_BYTES = BEAT_BYTES - PAD_BYTES;
    localparam int LOW_W      = KEEP_BYTES * 8;
    localparam int CARRY_W    = PAD_BYTES * 8;

    // One receive word together with its sideband, as held in the FIFO.
    typedef struct packed {
        logic              sof;
        logic              eof;
        logic              err;
        logic [OCC_W-1:0]  occ;
        logic [DATA_W-1:0] data;
    } rx_beat_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_TAIL = 2'd2
    } align_state_t;

    // Turns the occupancy code into a byte count (a code of 0 means a full word).
    function automatic logic [OCC_W:0] occ_to_count(input logic [OCC_W-1:0] occ);
        if (occ == '0) begin
            return (OCC_W+1)'(BEAT_BYTES);
        end
        return {1'b0, occ};
    endfunction

endpackage

// File: rtl/rxpad_skid_fifo.sv
// Module: rxpad_skid_fifo
// A small first-word-fall-through FIFO that takes in receive words while
// the output side is stalled. The write side has no back-pressure: a word
// that arrives while the FIFO is full is thrown away, and a registered drop
// flag reports it. DEPTH must be a power of two of at least 2.
module rxpad_skid_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         rd_pop,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         drop
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_ptr;
    logic [AW:0]  rd_ptr;
    logic         full;
    logic         empty;
    logic         push;
    logic         pop;

    assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign empty = (wr_ptr == rd_ptr);
    assign push  = wr_valid && !full;
    assign pop   = rd_pop && !empty;

    assign rd_valid = !empty;
    assign rd_data  = mem[rd_ptr[AW-1:0]];

    // Writes an accepted word into storage.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr[AW-1:0]] <= wr_data;
        end
    end

    // Moves the pointers; reset and clear empty the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    // Raises the drop flag for one cycle when a word was refused.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            drop <= 1'b0;
        end else begin
            drop <= wr_valid && full;
        end
    end

endmodule

// File: rtl/rxpad_shifter.sv
// Module: rxpad_shifter
// Frame aligner. It takes buffered words and builds each output word from
// the two low bytes of the current input word above the six bytes held
// over from the previous one. At start of frame the held-over bytes are
// replaced by the pad: the label, then zeros. A frame whose last word holds
// more than KEEP_BYTES bytes ends with one extra tail beat. It assumes the
// output stage takes a beat whenever slot_free is high.
module rxpad_shifter
    import rxpad_pkg::*;
#(
    parameter logic [7:0] PORT_LABEL = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              s_valid,
    input  rx_beat_t          s_beat,
    output logic              s_pop,
    input  logic              slot_free,
    output logic              o_emit,
    output logic [DATA_W-1:0] o_data,
    output logic [USER_W-1:0] o_user,
    output logic              o_last
);

    localparam logic [CARRY_W-1:0] PAD_WORD = {{(CARRY_W-8){1'b0}}, PORT_LABEL};

    align_state_t       state;
    logic [CARRY_W-1:0] carry;
    logic               tail_err;
    logic [OCC_W-1:0]   tail_occ;

    logic [OCC_W:0]     last_count;
    logic [OCC_W:0]     sum_count;
    logic [OCC_W:0]     tail_count;
    logic               needs_tail;
    logic               word_taken;
    logic [CARRY_W-1:0] low_part;

    assign last_count = occ_to_count(s_beat.occ);
    assign sum_count  = last_count + (OCC_W+1)'(PAD_BYTES);
    assign tail_count = last_count - (OCC_W+1)'(KEEP_BYTES);
    assign needs_tail = last_count > (OCC_W+1)'(KEEP_BYTES);
    assign low_part   = (state == ST_IDLE) ? PAD_WORD : carry;

    // A word is folded into the frame when it is popped and belongs to an open or opening frame.
    assign word_taken = s_pop && ((state == ST_BODY) || s_beat.sof);

    // Chooses the next output beat and whether the head word is popped.
    always_comb begin
        s_pop  = 1'b0;
        o_emit = 1'b0;
        o_data = {s_beat.data[LOW_W-1:0], low_part};
        o_user = '0;
        o_last = 1'b0;
        case (state)
            ST_TAIL: begin
                o_emit = 1'b1;
                o_data = {{LOW_W{1'b0}}, carry};
                o_last = 1'b1;
                o_user = {tail_err, tail_occ};
            end
            ST_IDLE: begin
                if (s_valid) begin
                    s_pop  = !s_beat.sof || slot_free;
                    o_emit = s_beat.sof;
                end
            end
            default: begin
                if (s_valid) begin
                    s_pop  = slot_free;
                    o_emit = 1'b1;
                end
            end
        endcase
        if (state != ST_TAIL && s_valid && s_beat.eof && !needs_tail) begin
            o_last = 1'b1;
            o_user = {s_beat.err, sum_count[OCC_W-1:0]};
        end
    end

    // Tracks frame position and keeps the upper six bytes of each folded word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state    <= ST_IDLE;
            carry    <= '0;
            tail_err <= 1'b0;
            tail_occ <= '0;
        end else if (state == ST_TAIL) begin
            if (slot_free) begin
                state <= ST_IDLE;
            end
        end else if (word_taken) begin
            carry <= s_beat.data[DATA_W-1:LOW_W];
            if (!s_beat.eof) begin
                state <= ST_BODY;
            end else if (needs_tail) begin
                state    <= ST_TAIL;
                tail_err <= s_beat.err;
                tail_occ <= tail_count[OCC_W-1:0];
            end else begin
                state <= ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/rxpad_out_stage.sv
// Module: rxpad_out_stage
// Output register with valid/ready flow control. It holds a beat until the
// sink takes it and offers its slot back to the aligner in the same cycle
// the held beat leaves. It assumes the aligner keeps the offered beat
// steady for as long as slot_free stays low.
module rxpad_out_stage
    import rxpad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              in_emit,
    input  logic [DATA_W-1:0] in_data,
    input  logic [USER_W-1:0] in_user,
    input  logic              in_last,
    output logic              slot_free,
    output logic [DATA_W-1:0] m_tdata,
    output logic [USER_W-1:0] m_tuser,
    output logic              m_tlast,
    output logic              m_tvalid,
    input  logic              m_tready
);

    assign slot_free = !m_tvalid || m_tready;

    // Tracks whether a beat is held; reset and clear empty the slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            m_tvalid <= 1'b0;
        end else if (slot_free) begin
            m_tvalid <= in_emit;
        end
    end

    // Captures the payload of a beat entering the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_tdata <= '0;
            m_tuser <= '0;
            m_tlast <= 1'b0;
        end else if (slot_free && in_emit) begin
            m_tdata <= in_data;
            m_tuser <= in_user;
            m_tlast <= in_last;
        end
    end

endmodule

// File: rtl/rxpad_top.sv
// Module: rxpad_top
// Receive pad inserter. Buffered words go through the six-byte aligner
// into a registered stream output. It assumes the source never stalls, so
// a full FIFO loses words and reports each loss on drop_pulse.
module rxpad_top
    import rxpad_pkg::*;
#(
    parameter logic [7:0] PORT_LABEL = 8'h00,
    parameter int         FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic [63:0] in_data,
    input  logic [2:0]  in_occ,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        in_err,
    input  logic        in_valid,
    output logic [63:0] m_tdata,
    output logic [3:0]  m_tuser,
    output logic        m_tlast,
    output logic        m_tvalid,
    input  logic        m_tready,
    output logic        drop_pulse
);

    localparam int BEAT_W = $bits(rx_beat_t);

    rx_beat_t          wr_beat;
    rx_beat_t          rd_beat;
    logic [BEAT_W-1:0] rd_flat;
    logic              rd_valid;
    logic              rd_pop;
    logic              slot_free;
    logic              emit;
    logic [DATA_W-1:0] emit_data;
    logic [USER_W-1:0] emit_user;
    logic              emit_last;

    // Packs the input pins into the buffered record.
    always_comb begin
        wr_beat.sof  = in_sof;
        wr_beat.eof  = in_eof;
        wr_beat.err  = in_err;
        wr_beat.occ  = in_occ;
        wr_beat.data = in_data;
    end

    assign rd_beat = rx_beat_t'(rd_flat);

    rxpad_skid_fifo #(
        .W     (BEAT_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .wr_valid (in_valid),
        .wr_data  (wr_beat),
        .rd_pop   (rd_pop),
        .rd_valid (rd_valid),
        .rd_data  (rd_flat),
        .drop     (drop_pulse)
    );

    rxpad_shifter #(
        .PORT_LABEL (PORT_LABEL)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .s_valid   (rd_valid),
        .s_beat    (rd_beat),
        .s_pop     (rd_pop),
        .slot_free (slot_free),
        .o_emit    (emit),
        .o_data    (emit_data),
        .o_user    (emit_user),
        .o_last    (emit_last)
    );

    rxpad_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .in_emit   (emit),
        .in_data   (emit_data),
        .in_user   (emit_user),
        .in_last   (emit_last),
        .slot_free (slot_free),
        .m_tdata   (m_tdata),
        .m_tuser   (m_tuser),
        .m_tlast   (m_tlast),
        .m_tvalid  (m_tvalid),
        .m_tready  (m_tready)
    );

endmodule

// File: rtl/rxpad_checker.sv
// Module: rxpad_checker
// Port-level properties of the pad inserter. It keeps its own record of
// whether an output frame is open, so that it can check the pad pattern
// on each first beat.
module rxpad_checker #(
    parameter logic [7:0] PORT_LABEL = 8'h00
) (
    input logic        clk,
    input logic        rst_n,
    input logic        clear,
    input logic        in_valid,
    input logic [63:0] m_tdata,
    input logic [3:0]  m_tuser,
    input logic        m_tlast,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic        drop_pulse
);

    logic in_frame;

    // Marks an output frame as open between its first beat and its tlast beat.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            in_frame <= 1'b0;
        end else if (m_tvalid && m_tready) begin
            in_frame <= !m_tlast;
        end
    end

    p_label_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !in_frame) |-> (m_tdata[7:0] == PORT_LABEL && m_tdata[47:8] == 40'd0));

    p_user_midframe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tlast) |-> (m_tuser == 4'd0));

    p_hold_stalled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready && !clear) |=>
            (m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast)));

    p_drop_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> $past(in_valid));

    p_clear_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !m_tvalid);

endmodule

bind rxpad_top rxpad_checker #(
    .PORT_LABEL (PORT_LABEL)
) u_rxpad_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .in_valid   (in_valid),
    .m_tdata    (m_tdata),
    .m_tuser    (m_tuser),
    .m_tlast    (m_tlast),
    .m_tvalid   (m_tvalid),
    .m_tready   (m_tready),
    .drop_pulse (drop_pulse)
);

// File: tb/rxpad_top_bench.sv
`timescale 1ns/1ps
module rxpad_top_bench;

    localparam logic [7:0] LBL = 8'h5A;
    localparam int FD = 4;
    localparam int NV = 8;
    // Fields: beats[24:20] occ[19:17] err[16] seed[15:8] exp_beats[7:3] exp_occ[2:0]
    localparam logic [24:0] VEC [NV] = '{
        {5'd1, 3'd1, 1'b0, 8'h10, 5'd1, 3'd7},
        {5'd1, 3'd2, 1'b0, 8'h20, 5'd1, 3'd0},
        {5'd1, 3'd3, 1'b1, 8'h30, 5'd2, 3'd1},
        {5'd1, 3'd0, 1'b0, 8'h40, 5'd2, 3'd6},
        {5'd3, 3'd2, 1'b1, 8'h50, 5'd3, 3'd0},
        {5'd8, 3'd5, 1'b0, 8'h60, 5'd9, 3'd3},
        {5'd4, 3'd7, 1'b1, 8'h70, 5'd5, 3'd5},
        {5'd2, 3'd0, 1'b0, 8'h80, 5'd3, 3'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic [63:0] in_data = '0;
    logic [2:0]  in_occ = '0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        in_err = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] m_tdata;
    logic [3:0]  m_tuser;
    logic        m_tlast;
    logic        m_tvalid;
    logic        m_tready = 1'b1;
    logic        drop_pulse;

    int errors = 0;
    int checks = 0;
    int rdy_mode = 0;
    int tick = 0;
    int cap_n = 0;
    int stray_drop = 0;
    bit drop_allowed = 0;
    bit done = 0;
    bit prev_stall = 0;
    bit prev_flush = 0;
    logic [63:0] prev_data;
    logic [63:0] cap_data [32];
    logic [3:0]  cap_user [32];
    logic        cap_last [32];

    always #2.5 clk = ~clk;

    rxpad_top #(.PORT_LABEL(LBL), .FIFO_DEPTH(FD)) u_rxpad_top (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .in_data(in_data), .in_occ(in_occ), .in_sof(in_sof), .in_eof(in_eof),
        .in_err(in_err), .in_valid(in_valid),
        .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .drop_pulse(drop_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sets ready for the coming edge, checks R6 holding and captures accepted beats.
    always @(negedge clk) begin
        tick++;
        case (rdy_mode)
            0: m_tready = 1'b1;
            1: m_tready = (tick % 3) != 2;
            default: m_tready = 1'b0;
        endcase
        if (prev_stall && !prev_flush) begin
            chk(m_tvalid && (m_tdata == prev_data), "R6 hold while stalled", m_tdata, prev_data);
        end
        if (rst_n && m_tvalid && m_tready && cap_n < 32) begin
            cap_data[cap_n] = m_tdata;
            cap_user[cap_n] = m_tuser;
            cap_last[cap_n] = m_tlast;
            cap_n++;
        end
        if (drop_pulse && !drop_allowed) stray_drop++;
        prev_stall = rst_n && m_tvalid && !m_tready;
        prev_flush = clear || !rst_n;
        prev_data  = m_tdata;
    end

    task automatic drive(input logic [63:0] d, input logic [2:0] occ, input bit sof, input bit eof, input bit err);
        @(posedge clk); #1;
        in_data = d; in_occ = occ; in_sof = sof; in_eof = eof; in_err = err; in_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0; in_data = '0;
        end
    endtask

    function automatic logic [63:0] in_word(input int nb, input int occ, input logic [7:0] seed, input int k);
        logic [63:0] w = '0;
        int n = (occ == 0) ? 8 : occ;
        for (int j = 0; j < 8; j++)
            if (k < nb - 1 || j < n) w[8*j +: 8] = 8'(int'(seed) + 8*k + j);
        return w;
    endfunction

    function automatic logic [63:0] out_word(input int len, input logic [7:0] seed, input int b);
        logic [63:0] w = '0;
        for (int j = 0; j < 8; j++) begin
            int p = 8*b + j;
            if (p == 0) w[7:0] = LBL;
            else if (p >= 6 && p < 6 + len) w[8*j +: 8] = 8'(int'(seed) + p - 6);
        end
        return w;
    endfunction

    task automatic send_frame(input int nb, input int occ, input bit err, input logic [7:0] seed, input int gap);
        for (int k = 0; k < nb; k++) begin
            drive(in_word(nb, occ, seed, k), 3'(occ), k == 0, k == nb - 1, err && (k == nb - 1));
            if (gap > 0) idle(gap);
        end
        idle(1);
    endtask

    task automatic expect_frame(input int nb, input int occ, input bit err, input logic [7:0] seed,
                                input int eb, input int eo);
        int len = 8*(nb - 1) + ((occ == 0) ? 8 : occ);
        for (int t = 0; t < 300 && cap_n < eb; t++) @(posedge clk);
        repeat (6) @(posedge clk);
        chk(cap_n == eb, "R3/R4 output beat count", 64'(cap_n), 64'(eb));
        for (int b = 0; b < eb && b < cap_n; b++) begin
            chk(cap_data[b] == out_word(len, seed, b), (b == 0) ? "R1 first beat pad" : "R2 shifted beat",
                cap_data[b], out_word(len, seed, b));
            chk(cap_last[b] == (b == eb - 1), "R3 tlast placement", 64'(cap_last[b]), 64'(b == eb - 1));
            if (b == eb - 1) begin
                chk(cap_user[b][2:0] == 3'(eo), (eb > nb) ? "R4 tail occupancy" : "R3 final occupancy",
                    64'(cap_user[b][2:0]), 64'(eo));
                chk(cap_user[b][3] == err, "R5 error on tlast", 64'(cap_user[b][3]), 64'(err));
            end else begin
                chk(cap_user[b] == 4'd0, "R5 tuser zero midframe", 64'(cap_user[b]), 64'd0);
            end
        end
    endtask

    task automatic run_vec(input int v, input int gap);
        logic [24:0] e = VEC[v];
        cap_n = 0;
        send_frame(int'(e[24:20]), int'(e[19:17]), e[16], e[15:8], gap);
        expect_frame(int'(e[24:20]), int'(e[19:17]), e[16], e[15:8], int'(e[7:3]), int'(e[2:0]));
    endtask

    task automatic pulse_clear;
        @(posedge clk); #1; clear = 1'b1;
        @(posedge clk); #1; clear = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R10 reset tvalid", 64'(m_tvalid), 64'd0);
        chk(drop_pulse == 1'b0, "R10 reset drop", 64'(drop_pulse), 64'd0);

        // Table pass with free-running ready, then with a stalling sink and a paced source.
        for (int v = 0; v < NV; v++) run_vec(v, 0);
        rdy_mode = 1;
        for (int v = 0; v < NV; v++) run_vec(v, 2);
        rdy_mode = 0;
        chk(stray_drop == 0, "R7 no drop at sustainable rate", 64'(stray_drop), 64'd0);

        // R8: a word without start-of-frame while idle produces nothing.
        cap_n = 0;
        drive(64'h1111_2222_3333_4444, 3'd0, 1'b0, 1'b1, 1'b1);
        idle(12);
        chk(cap_n == 0, "R8 stray word dropped", 64'(cap_n), 64'd0);
        run_vec(0, 0);

        // R7: stall the sink and overrun the FIFO.
        rdy_mode = 2; cap_n = 0; drop_allowed = 1;
        for (int k = 0; k < 6; k++) begin
            drive(in_word(6, 0, 8'h90, k), 3'd0, k == 0, k == 5, 1'b0);
            if (k > 0) chk(drop_pulse == 1'b0, "R7 no drop below capacity", 64'(drop_pulse), 64'd0);
        end
        idle(1);
        chk(drop_pulse == 1'b1, "R7 drop on full", 64'(drop_pulse), 64'd1);
        idle(1);
        chk(drop_pulse == 1'b0, "R7 drop is one cycle", 64'(drop_pulse), 64'd0);
        drop_allowed = 0;
        rdy_mode = 0;
        idle(20);
        chk(cap_n == 5, "R7 beats kept at capacity", 64'(cap_n), 64'd5);
        chk(cap_last[4] == 1'b0, "R7 lost end word leaves frame open", 64'(cap_last[4]), 64'd0);

        // R9: clear in the middle of a frame with data buffered.
        rdy_mode = 2;
        for (int k = 0; k < 3; k++) drive(in_word(5, 0, 8'hA0, k), 3'd0, k == 0, 1'b0, 1'b0);
        idle(4);
        chk(m_tvalid == 1'b1, "R9 beat pending before clear", 64'(m_tvalid), 64'd1);
        pulse_clear();
        chk(m_tvalid == 1'b0, "R9 clear empties output", 64'(m_tvalid), 64'd0);
        cap_n = 0; rdy_mode = 0;
        idle(10);
        chk(cap_n == 0, "R9 clear empties FIFO", 64'(cap_n), 64'd0);
        run_vec(5, 0);

        // R9: reset in the middle of a frame.
        rdy_mode = 2;
        for (int k = 0; k < 2; k++) drive(in_word(4, 0, 8'hB0, k), 3'd0, k == 0, 1'b0, 1'b0);
        idle(3);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        chk(m_tvalid == 1'b0, "R9 reset empties output", 64'(m_tvalid), 64'd0);
        cap_n = 0; rdy_mode = 0;
        idle(10);
        chk(cap_n == 0, "R9 reset discards partial frame", 64'(cap_n), 64'd0);
        run_vec(6, 0);

        done = 1;
        finish_run();
    end

endmodule